// File: doc/BRIEF.md
# Fixed-Token Dual-Rail Iteration Ring

This block applies one step operation many times over by sending a single data token around a closed loop of dual-rail stages. Each stage holds a true rail and a false rail for every data bit. A stage is either empty (a spacer, with both rails low on every bit) or full (exactly one rail high on every bit). Each stage is governed by a C-element that combines the completion of its upstream neighbour with the emptiness of its downstream neighbour. The last stage feeds the first, so once a token has been loaded it keeps moving with no further input. A clock is used only to step the emulated handshakes, and every stage advances once per clock.

A start request loads the operand, unmodified, into stage 0 as a dual-rail token. All other stages begin as spacers with their control elements low. From then on the token count never changes. Every stage that captures the token applies the step once, so one trip around the ring applies the step S times. A trip counter at stage 0 counts returns. When the number of trips reaches the requested target, the value that stage 0 would capture is placed on the result port and done pulses. In the same edge the ring is cleared to spacers.

Top module: `iter_ring`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy and done are low and result is zero. A reset during a run abandons that run.
- R2: When start is high and busy is low at a clock edge, that edge samples operand and trips, and busy is high from the next cycle.
- R3: The step is: rotate the DATA_W-bit value left by one bit, then add 1 modulo 2^DATA_W. The result equals the operand with STAGES × T steps applied, where T is the sampled trip target.
- R4: With the default five stages and one token, a trip lasts STAGES cycles. done is first high STAGES × T clock edges after the accepting edge, and it stays high for exactly one cycle.
- R5: busy falls on the same edge that done rises. result then holds its value until the next run completes.
- R6: A start request while busy is high has no effect. The run in progress keeps its operand, its trip target and its timing.
- R7: A trips value of 0 is treated as a target of 1.
- R8: A start that is high during the cycle in which the result is extracted is not accepted on that edge. If it is still high at the next edge, it is accepted there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Emulation clock; every stage handshake advances once per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to load a new token |
| operand | input | DATA_W | Starting value of the token |
| trips | input | TRIP_W | Number of trips to run (0 means 1) |
| busy | output | 1 | High while a token circulates |
| done | output | 1 | One-cycle pulse when the result is extracted |
| result | output | DATA_W | Last extracted value |

## Verification
Extraction and a new start request can fall in the same cycle. The bench holds start high across the end of a run, so the request is present in the cycle in which the final trip completes. The check is that busy is still low just after the extraction edge and rises one edge later. The restarted run must also yield the new operand's value at the correct cycle. A second overlap comes from pulsing start during an active run. That request must leave the run's final value and completion cycle unchanged.

// File: rtl/iter_ring_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the iteration ring.
// Assumes: nothing beyond IEEE 1800-2017.
package iter_ring_pkg;
    // Run state of the ring controller.
    typedef enum logic {
        RING_IDLE = 1'b0,
        RING_RUN  = 1'b1
    } ring_mode_e;

    // Smallest ring that keeps one token moving.
    localparam int RING_MIN_STAGES = 3;
endpackage

// File: rtl/ring_step_fn.sv
`timescale 1ns/1ps
// Module: ring_step_fn
// The recursive step applied at each stage capture: rotate left by one bit, then add one.
// Assumes: W >= 2.
module ring_step_fn #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    // Combinational step.
    always_comb y = {x[W-2:0], x[W-1]} + W'(1);
endmodule

// File: rtl/ring_cdet.sv
`timescale 1ns/1ps
// Module: ring_cdet
// Completion detector for one dual-rail word. full is high only when every bit has a rail raised.
// Assumes: rails are updated together, so no partial word is ever observed.
module ring_cdet #(
    parameter int W = 16
) (
    input  logic [W-1:0] rail_t,
    input  logic [W-1:0] rail_f,
    output logic         full
);
    // Reduce the per-bit presence to one flag.
    always_comb full = &(rail_t | rail_f);
endmodule

// File: rtl/ring_stage.sv
`timescale 1ns/1ps
// Module: ring_stage
// One ring stage. A C-element merges upstream completion with downstream emptiness.
// On its rising edge the stage captures the stepped upstream word. On its falling edge
// the stage returns to a spacer. Stage 0 can also be loaded directly, and any stage can be flushed.
// Assumes: upstream rails are legal dual-rail (at most one rail high per bit).
module ring_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         pred_full,
    input  logic         succ_full,
    input  logic [W-1:0] pred_t,
    input  logic [W-1:0] pred_f,
    output logic         phase,
    output logic         capt,
    output logic [W-1:0] rail_t,
    output logic [W-1:0] rail_f
);
    logic         c_nxt;
    logic         rel;
    logic [W-1:0] pred_val;
    logic [W-1:0] step_val;

    // C-element: rise on (full upstream, empty downstream); fall on the opposite; otherwise hold.
    always_comb begin
        c_nxt = (pred_full & ~succ_full) | (phase & (pred_full | ~succ_full));
        capt  = ~phase & c_nxt;
        rel   = phase & ~c_nxt;
    end

    // Decode the upstream word from its true rail, qualified by the false rail.
    always_comb pred_val = pred_t & ~pred_f;

    ring_step_fn #(.W(W)) u_step (
        .x (pred_val),
        .y (step_val)
    );

    // Stage storage: control bit and both rails.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            phase  <= 1'b0;
            rail_t <= '0;
            rail_f <= '0;
        end else if (load) begin
            phase  <= 1'b1;
            rail_t <= load_val;
            rail_f <= ~load_val;
        end else if (capt) begin
            phase  <= 1'b1;
            rail_t <= step_val;
            rail_f <= ~step_val;
        end else if (rel) begin
            phase  <= 1'b0;
            rail_t <= '0;
            rail_f <= '0;
        end
    end
endmodule

// File: rtl/ring_trip_ctr.sv
`timescale 1ns/1ps
// Module: ring_trip_ctr
// Counts token returns to stage 0. It flags the return that completes the requested number of trips.
// Assumes: clear and tick never coincide. A target of 0 is stored as 1.
module ring_trip_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [CW-1:0] tgt_in,
    input  logic          tick,
    output logic          last
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] tgt_q;
    logic [CW:0]   cnt_inc;

    // Compare the count that this tick would reach against the target.
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + (CW+1)'(1);
        last    = tick & (cnt_inc >= {1'b0, tgt_q});
    end

    // Count register and target latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgt_q <= CW'(1);
        end else if (clear) begin
            cnt_q <= '0;
            tgt_q <= (tgt_in == '0) ? CW'(1) : tgt_in;
        end else if (tick) begin
            cnt_q <= cnt_inc[CW-1:0];
        end
    end
endmodule

// File: rtl/iter_ring.sv
`timescale 1ns/1ps
// Module: iter_ring
// A fixed-token self-timed ring of STAGES dual-rail stages. Stage STAGES-1 feeds stage 0.
// A start request loads one token. After the requested number of trips, the stepped word
// is extracted, done pulses and the ring is flushed to spacers.
// Assumes: STAGES >= 3. Full speed (one stage per cycle) needs STAGES >= 4 with one token.
module iter_ring #(
    parameter int STAGES = 5,
    parameter int DATA_W = 16,
    parameter int TRIP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    input  logic [TRIP_W-1:0] trips,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    import iter_ring_pkg::*;

    localparam int LAST = STAGES - 1;

    ring_mode_e                      mode_q;
    logic                            accept;
    logic                            extract;
    logic [STAGES-1:0]               phase_vec;
    logic [STAGES-1:0]               capt_vec;
    logic [STAGES-1:0]               full_vec;
    logic [STAGES-1:0][DATA_W-1:0]   rail_t;
    logic [STAGES-1:0][DATA_W-1:0]   rail_f;
    logic [DATA_W-1:0]               tail_val;
    logic [DATA_W-1:0]               tail_step;
    logic                            done_q;
    logic [DATA_W-1:0]               result_q;

    // A new token is taken only while no run is active.
    always_comb accept = start & (mode_q == RING_IDLE);

    // Build the stages and their completion detectors around the loop.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        localparam int PI = (g == 0) ? LAST : g - 1;
        localparam int SI = (g == LAST) ? 0 : g + 1;

        ring_cdet #(.W(DATA_W)) u_det (
            .rail_t (rail_t[g]),
            .rail_f (rail_f[g]),
            .full   (full_vec[g])
        );

        ring_stage #(.W(DATA_W)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (extract),
            .load      ((g == 0) ? accept : 1'b0),
            .load_val  (operand),
            .pred_full (full_vec[PI]),
            .succ_full (full_vec[SI]),
            .pred_t    (rail_t[PI]),
            .pred_f    (rail_f[PI]),
            .phase     (phase_vec[g]),
            .capt      (capt_vec[g]),
            .rail_t    (rail_t[g]),
            .rail_f    (rail_f[g])
        );
    end

    ring_trip_ctr #(.CW(TRIP_W)) u_trips (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .tgt_in (trips),
        .tick   (capt_vec[0] & (mode_q == RING_RUN)),
        .last   (extract)
    );

    // The value stage 0 would capture from the tail is the extracted result.
    always_comb tail_val = rail_t[LAST] & ~rail_f[LAST];

    ring_step_fn #(.W(DATA_W)) u_tail_step (
        .x (tail_val),
        .y (tail_step)
    );

    // Run state, done pulse and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= RING_IDLE;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= extract;
            if (accept) begin
                mode_q <= RING_RUN;
            end else if (extract) begin
                mode_q   <= RING_IDLE;
                result_q <= tail_step;
            end
        end
    end

    // Drive the outputs.
    always_comb begin
        busy   = (mode_q == RING_RUN);
        done   = done_q;
        result = result_q;
    end
endmodule

// File: rtl/iter_ring_chk.sv
`timescale 1ns/1ps
// Module: iter_ring_chk
// Property checker for iter_ring, attached by bind. It observes the ports plus the stage phases,
// the detector outputs and the rails.
// Assumes: one token is loaded per run.
module iter_ring_chk #(
    parameter int STAGES = 5,
    parameter int DATA_W = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          start,
    input logic                          busy,
    input logic                          done,
    input logic [STAGES-1:0]             phase_vec,
    input logic [STAGES-1:0]             full_vec,
    input logic [STAGES-1:0][DATA_W-1:0] rail_t,
    input logic [STAGES-1:0][DATA_W-1:0] rail_f
);
    // R2: an idle start is taken at once.
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R4: done lasts one cycle.
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: busy ends on the edge that raises done.
    a_r5_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R5: an idle ring holds only spacers.
    a_r5_idle_drained: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (phase_vec == '0));

    // R3: each control element agrees with its detector.
    a_r3_phase_rails: assert property (@(posedge clk) disable iff (!rst_n)
        full_vec == phase_vec);

    // R3: no bit ever has both rails high.
    a_r3_rail_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_t & rail_f) == '0);

    // R3: one token with its trailing copy covers one or two stages.
    a_r3_one_token: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(phase_vec) >= 1 && $countones(phase_vec) <= 2));
endmodule

bind iter_ring iter_ring_chk #(.STAGES(STAGES), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .phase_vec (phase_vec),
    .full_vec  (full_vec),
    .rail_t    (rail_t),
    .rail_f    (rail_f)
);

// File: tb/iter_ring_tb.sv
`timescale 1ns/1ps
// Bench for iter_ring. It walks a vector table, then runs directed reset and overlap cases.
module iter_ring_tb;
    localparam int S  = 5;
    localparam int W  = 16;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  operand = '0;
    logic [TW-1:0] trips = '0;
    logic          busy;
    logic          done;
    logic [W-1:0]  result;

    int checks = 0;
    int fails  = 0;

    iter_ring #(.STAGES(S), .DATA_W(W), .TRIP_W(TW)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .operand (operand),
        .trips   (trips),
        .busy    (busy),
        .done    (done),
        .result  (result)
    );

    always #5 clk = ~clk;

    // Stimulus table: operand in bits 23:8, trip target in bits 7:0.
    localparam logic [23:0] VEC [6] = '{
        {16'h0000, 8'd1}, {16'hFFFF, 8'd2}, {16'h1234, 8'd3},
        {16'h8001, 8'd1}, {16'hA5A5, 8'd4}, {16'h00FF, 8'd7}
    };

    function automatic logic [W-1:0] model(input logic [W-1:0] x, input int n);
        logic [W-1:0] v = x;
        for (int k = 0; k < n; k++) v = {v[W-2:0], v[W-1]} + W'(1);
        return v;
    endfunction

    function automatic int eff(input logic [TW-1:0] t);
        return (t == 0) ? 1 : int'(t);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Request a start at a falling edge. Return at the falling edge after the accepting edge.
    task automatic start_run(input logic [W-1:0] op, input logic [TW-1:0] t);
        @(negedge clk);
        start = 1'b1; operand = op; trips = t;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Advance falling edge by falling edge until done, counting edges.
    task automatic wait_done(inout int n);
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy in reset", 32'(busy), 0);
        chk(done == 1'b0, "R1 done in reset", 32'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(result == '0, "R1 result after reset", 32'(result), 0);
        chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);

        // Table walk: R2, R3, R4, R5
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0]  op = VEC[i][23:8];
            logic [TW-1:0] t  = VEC[i][7:0];
            start_run(op, t);
            n = 0;
            chk(busy == 1'b1, "R2 busy after accept", 32'(busy), 1);
            wait_done(n);
            chk(n == S * eff(t), "R4 completion cycle", 32'(n), 32'(S * eff(t)));
            chk(result == model(op, S * eff(t)), "R3 result", 32'(result), 32'(model(op, S * eff(t))));
            chk(busy == 1'b0, "R5 busy falls with done", 32'(busy), 0);
            held = result;
            @(negedge clk);
            chk(done == 1'b0, "R4 done single cycle", 32'(done), 0);
            chk(result == held, "R5 result holds", 32'(result), 32'(held));
        end

        // R7: a target of 0 runs one trip
        start_run(16'h4321, 8'd0);
        n = 0;
        wait_done(n);
        chk(n == S, "R7 zero target cycles", 32'(n), 32'(S));
        chk(result == model(16'h4321, S), "R7 zero target result", 32'(result), 32'(model(16'h4321, S)));

        // R6: a start during a run changes nothing
        start_run(16'h0F0F, 8'd2);
        n = 0;
        repeat (3) begin @(negedge clk); n++; end
        start = 1'b1; operand = 16'hBEEF; trips = 8'd1;
        @(negedge clk); n++;
        start = 1'b0;
        wait_done(n);
        chk(n == 2 * S, "R6 timing unchanged", 32'(n), 32'(2 * S));
        chk(result == model(16'h0F0F, 2 * S), "R6 operand unchanged", 32'(result), 32'(model(16'h0F0F, 2 * S)));

        // R8: start held through extraction is accepted one edge later
        @(negedge clk);
        start = 1'b1; operand = 16'h1357; trips = 8'd1;
        @(posedge clk);
        @(negedge clk);
        n = 0;
        wait_done(n);
        chk(n == S, "R8 first run cycles", 32'(n), 32'(S));
        chk(busy == 1'b0, "R8 not taken at extraction", 32'(busy), 0);
        operand = 16'h2468; trips = 8'd2;
        @(negedge clk); n++;
        chk(busy == 1'b1, "R8 taken next edge", 32'(busy), 1);
        start = 1'b0;
        wait_done(n);
        chk(n == S + 1 + 2 * S, "R8 second run cycles", 32'(n), 32'(S + 1 + 2 * S));
        chk(result == model(16'h2468, 2 * S), "R8 second run result", 32'(result), 32'(model(16'h2468, 2 * S)));

        // R1: reset during a run
        start_run(16'h7777, 8'd5);
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after mid-run reset", 32'(busy), 0);
        chk(done == 1'b0, "R1 done after mid-run reset", 32'(done), 0);
        chk(result == '0, "R1 result after mid-run reset", 32'(result), 0);
        rst_n = 1'b1;
        start_run(16'h0001, 8'd1);
        n = 0;
        wait_done(n);
        chk(result == model(16'h0001, S), "R3 result after reset", 32'(result), 32'(model(16'h0001, S)));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule